// File: doc/BRIEF.md
# Quadrature and Up/Down Event Counter

This block keeps a signed 32-bit position or event count driven by three external pins: two count inputs (A and B) and a marker input (Z). It can treat A and B as a two-bit Gray-coded quadrature pair from a motor encoder or thumb wheel, or as a plain two-bit binary value. It can also run as an up/down counter, taking the direction either from the level of A or from two separate edge inputs. Each pin goes through a two-flop synchroniser and then a debouncer. The debouncer's filter time is set in the control register.

Programmable lower and upper limits are checked whenever the count steps. For each limit, crossing it either sets a sticky warning flag or returns the count to zero, as configured. A rising edge on Z either clears the count or is passed on as a one-cycle push-button event. A one-cycle strobe marks every counting step, so an external timer can measure the time between events. A simple register write port sets the configuration, loads the count and clears the flags.

Top module: `enc_event_counter`

## Requirements
- R1: After a synchronous reset, `count` is 0, all flags and strobes are 0, the lower limit is 0x80000000, the upper limit is 0x7FFFFFFF, and the control register is 0 (quadrature mode, no filtering).
- R2: Each pin is synchronised through two flops. With filter field N (control bits [7:4]) nonzero, a new level is accepted only after the synchronised level has differed from the accepted level on 2^N consecutive clocks. Shorter pulses have no effect. N = 0 bypasses the filter.
- R3: Mode 0 (control bits [1:0] = 0) is quadrature. The code {A,B} stepping 00→01→11→10→00 adds one per transition, and the reverse order subtracts one per transition.
- R4: In mode 0, a change of both bits at once leaves the count unchanged and sets the sticky `quad_err` flag.
- R5: Mode 1 is binary. Each change of the unsigned value {A,B} adds the signed difference new minus old (range -3 to +3) to the count.
- R6: Mode 2 is direction-level. Each rising edge of B adds one when A is high and subtracts one when A is low.
- R7: Mode 3 is two-edge. A rising edge of A adds one and a rising edge of B subtracts one. Both edges in the same cycle leave the count unchanged.
- R8: `count_evt` is high for exactly one cycle, on the same edge as the count update, for every nonzero step (including a step that auto-zeroes). It is never high otherwise.
- R9: With control bit 2 set, a rising edge of Z clears the count, and this overrides a step in the same cycle. With bit 2 clear, the edge pulses `button_evt` for one cycle and leaves the count alone.
- R10: If a step would make the count greater than the upper limit (signed): with control bit 9 set the count becomes 0; otherwise the count takes the stepped value and the sticky `max_flag` is set.
- R11: If a step would make the count less than the lower limit (signed): with control bit 8 set the count becomes 0; otherwise the count takes the stepped value and the sticky `min_flag` is set.
- R12: Writes: address 0 writes control, address 1 the lower limit, address 2 the upper limit, and address 3 loads the count (this overrides everything else). Address 4 clears flags where data bit 0 selects `min_flag`, bit 1 `max_flag` and bit 2 `quad_err`. A flag that is set in the same cycle stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_a | input | 1 | Count input A (asynchronous) |
| enc_b | input | 1 | Count input B (asynchronous) |
| enc_z | input | 1 | Zero marker / push-button input (asynchronous) |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| count | output | 32 | Signed count value |
| count_evt | output | 1 | One-cycle strobe per counting step |
| button_evt | output | 1 | One-cycle push-button event |
| min_flag | output | 1 | Sticky lower-limit warning |
| max_flag | output | 1 | Sticky upper-limit warning |
| quad_err | output | 1 | Sticky illegal quadrature transition |

## Verification
The hardest case to reach from the pins is a filtered pulse that is almost, but not quite, long enough to be accepted, combined with the pipeline delay from pin to count. The stimulus sets a nonzero filter length, drives a pulse a few cycles shorter than 2^N and then one that is much longer. A cycle-accurate model that includes the sync and filter delay is compared on every clock. The limit actions also need the count to be preloaded near a limit through the load address, so that a few single steps cross it in both the flagging and the auto-zero setting.

// File: rtl/enc_cnt_pkg.sv
package enc_cnt_pkg;

    typedef enum logic [1:0] {
        MODE_QUAD    = 2'd0,
        MODE_BIN     = 2'd1,
        MODE_DIRLVL  = 2'd2,
        MODE_TWOEDGE = 2'd3
    } cnt_mode_e;

    localparam int FILT_NW = 4;

    typedef struct packed {
        logic               max_az;
        logic               min_az;
        logic [FILT_NW-1:0] filt_n;
        logic               z_clears;
        cnt_mode_e          mode;
    } ctrl_t;

    localparam logic [2:0] ADDR_CTRL = 3'd0;
    localparam logic [2:0] ADDR_MIN  = 3'd1;
    localparam logic [2:0] ADDR_MAX  = 3'd2;
    localparam logic [2:0] ADDR_LOAD = 3'd3;
    localparam logic [2:0] ADDR_CLR  = 3'd4;

    function automatic logic [1:0] gray_to_bin(input logic [1:0] g);
        return {g[1], g[1] ^ g[0]};
    endfunction

endpackage

// File: rtl/enc_debounce.sv
module enc_debounce #(
    parameter int NW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          raw_i,
    input  logic [NW-1:0] filt_n_i,
    output logic          lvl_o
);
    localparam int CNT_W = 1 << NW;

    logic             sync1_q, sync2_q, held_q;
    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] limit;

    assign limit = (CNT_W'(1) << filt_n_i) - CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            held_q  <= 1'b0;
            run_q   <= '0;
        end else begin
            sync1_q <= raw_i;
            sync2_q <= sync1_q;
            if (filt_n_i == '0) begin
                held_q <= sync2_q;
                run_q  <= '0;
            end else if (sync2_q == held_q) begin
                run_q <= '0;
            end else if (run_q == limit) begin
                held_q <= sync2_q;
                run_q  <= '0;
            end else begin
                run_q <= run_q + CNT_W'(1);
            end
        end
    end

    assign lvl_o = (filt_n_i == '0) ? sync2_q : held_q;

    // R2
    db_accept_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(filt_n_i) != '0 && held_q != $past(held_q)) |-> ($past(sync2_q) != $past(held_q)));

endmodule

// File: rtl/enc_step_decode.sv
module enc_step_decode
    import enc_cnt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cnt_mode_e         mode_i,
    input  logic              a_i,
    input  logic              b_i,
    input  logic              z_i,
    output logic signed [3:0] step_o,
    output logic              quad_err_o,
    output logic              z_rise_o
);
    logic       pa_q, pb_q, pz_q;
    logic [1:0] qdiff;

    always_ff @(posedge clk) begin
        if (rst) begin
            pa_q <= 1'b0;
            pb_q <= 1'b0;
            pz_q <= 1'b0;
        end else begin
            pa_q <= a_i;
            pb_q <= b_i;
            pz_q <= z_i;
        end
    end

    assign qdiff = gray_to_bin({a_i, b_i}) - gray_to_bin({pa_q, pb_q});

    always_comb begin
        step_o     = 4'sd0;
        quad_err_o = 1'b0;
        unique case (mode_i)
            MODE_QUAD: begin
                case (qdiff)
                    2'd1:    step_o = 4'sd1;
                    2'd3:    step_o = -4'sd1;
                    2'd2:    quad_err_o = 1'b1;
                    default: step_o = 4'sd0;
                endcase
            end
            MODE_BIN: begin
                step_o = $signed({2'b00, a_i, b_i}) - $signed({2'b00, pa_q, pb_q});
            end
            MODE_DIRLVL: begin
                if (b_i && !pb_q) step_o = a_i ? 4'sd1 : -4'sd1;
            end
            MODE_TWOEDGE: begin
                step_o = $signed({3'b000, a_i & ~pa_q}) - $signed({3'b000, b_i & ~pb_q});
            end
            default: step_o = 4'sd0;
        endcase
    end

    assign z_rise_o = z_i & ~pz_q;

endmodule

// File: rtl/enc_count_core.sv
module enc_count_core
    import enc_cnt_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  ctrl_t                ctrl_i,
    input  logic signed [CW-1:0] lo_lim_i,
    input  logic signed [CW-1:0] hi_lim_i,
    input  logic signed [3:0]    step_i,
    input  logic                 quad_err_i,
    input  logic                 z_rise_i,
    input  logic                 ld_i,
    input  logic [CW-1:0]        ld_val_i,
    input  logic [2:0]           clr_i,
    output logic signed [CW-1:0] count_o,
    output logic                 evt_o,
    output logic                 btn_o,
    output logic                 min_flag_o,
    output logic                 max_flag_o,
    output logic                 err_flag_o
);
    logic signed [CW-1:0] cand, nxt, step_ext;
    logic                 evt_d, set_min, set_max, zclr;

    assign step_ext = {{(CW-4){step_i[3]}}, step_i};
    assign cand     = count_o + step_ext;
    assign zclr     = z_rise_i && ctrl_i.z_clears;

    always_comb begin
        nxt     = count_o;
        evt_d   = 1'b0;
        set_min = 1'b0;
        set_max = 1'b0;
        if (ld_i) begin
            nxt = $signed(ld_val_i);
        end else if (zclr) begin
            nxt = '0;
        end else if (step_i != 4'sd0) begin
            evt_d = 1'b1;
            if (cand > hi_lim_i) begin
                if (ctrl_i.max_az) nxt = '0;
                else begin
                    nxt     = cand;
                    set_max = 1'b1;
                end
            end else if (cand < lo_lim_i) begin
                if (ctrl_i.min_az) nxt = '0;
                else begin
                    nxt     = cand;
                    set_min = 1'b1;
                end
            end else begin
                nxt = cand;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_o    <= '0;
            evt_o      <= 1'b0;
            btn_o      <= 1'b0;
            min_flag_o <= 1'b0;
            max_flag_o <= 1'b0;
            err_flag_o <= 1'b0;
        end else begin
            count_o    <= nxt;
            evt_o      <= evt_d;
            btn_o      <= z_rise_i && !ctrl_i.z_clears;
            min_flag_o <= (min_flag_o & ~clr_i[0]) | set_min;
            max_flag_o <= (max_flag_o & ~clr_i[1]) | set_max;
            err_flag_o <= (err_flag_o & ~clr_i[2]) | quad_err_i;
        end
    end

    // R8
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!evt_o && !$past(ld_i) && !$past(zclr)) |-> (count_o == $past(count_o)));

    // R4
    quad_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $past(quad_err_i && !ld_i && !zclr) |-> (count_o == $past(count_o)));

    // R4
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(err_flag_o) && !$past(clr_i[2])) |-> err_flag_o);

    // R10
    max_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(max_flag_o) && !$past(clr_i[1])) |-> max_flag_o);

    // R9
    zero_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(zclr && !ld_i) |-> (count_o == '0 && !evt_o));

endmodule

// File: rtl/enc_event_counter.sv
module enc_event_counter
    import enc_cnt_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int AW    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enc_a,
    input  logic             enc_b,
    input  logic             enc_z,
    input  logic             cfg_we,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [CNT_W-1:0] cfg_wdata,
    output logic [CNT_W-1:0] count,
    output logic             count_evt,
    output logic             button_evt,
    output logic             min_flag,
    output logic             max_flag,
    output logic             quad_err
);
    localparam int NPIN = 3;

    ctrl_t                   ctrl_q;
    logic signed [CNT_W-1:0] lo_q, hi_q, count_s;
    logic [NPIN-1:0]         pin_raw, pin_lvl;
    logic signed [3:0]       step;
    logic                    q_err, z_rise, ld, unused_bits;
    logic [2:0]              clr;

    assign pin_raw = {enc_z, enc_b, enc_a};

    generate
        for (genvar i = 0; i < NPIN; i++) begin : g_pin
            enc_debounce #(.NW(FILT_NW)) u_db (
                .clk      (clk),
                .rst      (rst),
                .raw_i    (pin_raw[i]),
                .filt_n_i (ctrl_q.filt_n),
                .lvl_o    (pin_lvl[i])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            lo_q   <= {1'b1, {(CNT_W-1){1'b0}}};
            hi_q   <= {1'b0, {(CNT_W-1){1'b1}}};
        end else if (cfg_we) begin
            case (AW'(cfg_addr))
                AW'(ADDR_CTRL): begin
                    ctrl_q.mode     <= cnt_mode_e'(cfg_wdata[1:0]);
                    ctrl_q.z_clears <= cfg_wdata[2];
                    ctrl_q.filt_n   <= cfg_wdata[7:4];
                    ctrl_q.min_az   <= cfg_wdata[8];
                    ctrl_q.max_az   <= cfg_wdata[9];
                end
                AW'(ADDR_MIN): lo_q <= $signed(cfg_wdata);
                AW'(ADDR_MAX): hi_q <= $signed(cfg_wdata);
                default: ;
            endcase
        end
    end

    assign ld          = cfg_we && (cfg_addr == AW'(ADDR_LOAD));
    assign clr         = (cfg_we && (cfg_addr == AW'(ADDR_CLR))) ? cfg_wdata[2:0] : 3'b000;
    assign unused_bits = ^{cfg_wdata[CNT_W-1:10], cfg_wdata[3]};

    enc_step_decode u_dec (
        .clk        (clk),
        .rst        (rst),
        .mode_i     (ctrl_q.mode),
        .a_i        (pin_lvl[0]),
        .b_i        (pin_lvl[1]),
        .z_i        (pin_lvl[2]),
        .step_o     (step),
        .quad_err_o (q_err),
        .z_rise_o   (z_rise)
    );

    enc_count_core #(.CW(CNT_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .ctrl_i     (ctrl_q),
        .lo_lim_i   (lo_q),
        .hi_lim_i   (hi_q),
        .step_i     (step),
        .quad_err_i (q_err),
        .z_rise_i   (z_rise),
        .ld_i       (ld),
        .ld_val_i   (cfg_wdata),
        .clr_i      (clr),
        .count_o    (count_s),
        .evt_o      (count_evt),
        .btn_o      (button_evt),
        .min_flag_o (min_flag),
        .max_flag_o (max_flag),
        .err_flag_o (quad_err)
    );

    assign count = count_s;

endmodule

// File: tb/enc_event_counter_bench.sv
`timescale 1ns/1ps
module enc_event_counter_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enc_a = 0, enc_b = 0, enc_z = 0;
    logic        cfg_we = 0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] count;
    logic        count_evt, button_evt, min_flag, max_flag, quad_err;

    int    vectors = 0;
    int    miscompares = 0;
    string req_tag = "R1";

    always #2.5 clk = ~clk;

    enc_event_counter u_enc_event_counter (
        .clk(clk), .rst(rst), .enc_a(enc_a), .enc_b(enc_b), .enc_z(enc_z),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .count(count), .count_evt(count_evt), .button_evt(button_evt),
        .min_flag(min_flag), .max_flag(max_flag), .quad_err(quad_err)
    );

    // ---------------- behavioural reference ----------------
    bit pipe1[3], pipe2[3], acc[3], prv[3], f[3];
    int runlen[3];
    int m_mode, m_n, step, qd;
    bit m_zc, m_minaz, m_maxaz;
    logic signed [31:0] m_lo, m_hi, m_cnt, cand;
    bit m_evt, m_btn, m_fmin, m_fmax, m_ferr, ld, zc, qerr;
    logic [2:0] clrm;

    function automatic int qpos(bit a, bit b);
        if (!a && !b) return 0;
        if (!a &&  b) return 1;
        if ( a &&  b) return 2;
        return 3;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 3; i++) begin
                pipe1[i] = 0; pipe2[i] = 0; acc[i] = 0; prv[i] = 0; runlen[i] = 0;
            end
            m_mode = 0; m_n = 0; m_zc = 0; m_minaz = 0; m_maxaz = 0;
            m_lo = 32'sh80000000; m_hi = 32'sh7fffffff; m_cnt = 0;
            m_evt = 0; m_btn = 0; m_fmin = 0; m_fmax = 0; m_ferr = 0;
        end else begin
            for (int i = 0; i < 3; i++) f[i] = (m_n == 0) ? pipe2[i] : acc[i];
            step = 0; qerr = 0;
            case (m_mode)
                0: begin
                    qd = (qpos(f[0], f[1]) - qpos(prv[0], prv[1]) + 4) % 4;
                    if (qd == 1) step = 1;
                    else if (qd == 3) step = -1;
                    else if (qd == 2) qerr = 1;
                end
                1: step = (2*f[0] + f[1]) - (2*prv[0] + prv[1]);
                2: if (f[1] && !prv[1]) step = f[0] ? 1 : -1;
                default: step = (f[0] && !prv[0] ? 1 : 0) - (f[1] && !prv[1] ? 1 : 0);
            endcase
            ld   = cfg_we && cfg_addr == 3;
            clrm = (cfg_we && cfg_addr == 4) ? cfg_wdata[2:0] : 3'b0;
            zc   = f[2] && !prv[2];
            m_fmin = m_fmin & !clrm[0];
            m_fmax = m_fmax & !clrm[1];
            m_ferr = (m_ferr & !clrm[2]) | qerr;
            m_btn = zc && !m_zc;
            m_evt = 0;
            cand  = m_cnt + step;
            if (ld) m_cnt = cfg_wdata;
            else if (zc && m_zc) m_cnt = 0;
            else if (step != 0) begin
                m_evt = 1;
                if (cand > m_hi) begin
                    if (m_maxaz) m_cnt = 0; else begin m_cnt = cand; m_fmax = 1; end
                end else if (cand < m_lo) begin
                    if (m_minaz) m_cnt = 0; else begin m_cnt = cand; m_fmin = 1; end
                end else m_cnt = cand;
            end
            for (int i = 0; i < 3; i++) begin
                prv[i] = f[i];
                if (m_n == 0) begin acc[i] = pipe2[i]; runlen[i] = 0; end
                else if (pipe2[i] == acc[i]) runlen[i] = 0;
                else if (runlen[i] == (1 << m_n) - 1) begin acc[i] = pipe2[i]; runlen[i] = 0; end
                else runlen[i] = runlen[i] + 1;
                pipe2[i] = pipe1[i];
            end
            pipe1[0] = enc_a; pipe1[1] = enc_b; pipe1[2] = enc_z;
            if (cfg_we) begin
                case (cfg_addr)
                    0: begin
                        m_mode = cfg_wdata[1:0]; m_zc = cfg_wdata[2]; m_n = cfg_wdata[7:4];
                        m_minaz = cfg_wdata[8]; m_maxaz = cfg_wdata[9];
                    end
                    1: m_lo = cfg_wdata;
                    2: m_hi = cfg_wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            chk(req_tag, "count", count, m_cnt);
            chk("R8", "count_evt", {31'b0, count_evt}, {31'b0, m_evt});
            chk("R9", "button_evt", {31'b0, button_evt}, {31'b0, m_btn});
            chk("R11", "min_flag", {31'b0, min_flag}, {31'b0, m_fmin});
            chk("R10", "max_flag", {31'b0, max_flag}, {31'b0, m_fmax});
            chk("R4", "quad_err", {31'b0, quad_err}, {31'b0, m_ferr});
        end
    end

    // ---------------- stimulus ----------------
    task automatic put(bit a, bit b, bit z, int n);
        @(negedge clk);
        enc_a = a; enc_b = b; enc_z = z;
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [2:0] adr, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_addr = adr; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        vectors++; miscompares++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1", "reset count", count, 32'h0);
        chk("R1", "reset flags", {27'b0, count_evt, button_evt, min_flag, max_flag, quad_err}, 32'h0);

        req_tag = "R3";
        for (int k = 0; k < 2; k++) begin
            put(0,1,0,4); put(1,1,0,4); put(1,0,0,4); put(0,0,0,4);
        end
        put(1,0,0,4); put(1,1,0,6);
        chk("R3", "quad up 8 down 2", count, 32'd6);

        req_tag = "R4";
        put(0,0,0,6);
        chk("R4", "illegal jump count", count, 32'd6);
        chk("R4", "illegal jump flag", {31'b0, quad_err}, 32'd1);
        wr(4, 32'h4);
        @(negedge clk);
        chk("R12", "flag clear", {31'b0, quad_err}, 32'd0);

        req_tag = "R2";
        wr(0, 32'h30);
        put(0,1,0,4); put(0,0,0,16);
        chk("R2", "short glitch ignored", count, 32'd6);
        put(0,1,0,20);
        chk("R2", "stable level accepted", count, 32'd7);

        req_tag = "R5";
        wr(0, 32'h1);
        put(1,1,0,5); put(0,0,0,5); put(1,0,0,6);
        chk("R5", "binary diffs", count, 32'd8);

        req_tag = "R6";
        wr(0, 32'h2);
        put(1,0,0,5); put(1,1,0,5); put(1,0,0,5); put(1,1,0,5);
        put(0,0,0,5); put(0,1,0,6);
        chk("R6", "dir level", count, 32'd9);

        req_tag = "R7";
        wr(0, 32'h3);
        put(0,0,0,5); put(1,0,0,5); put(0,0,0,5); put(0,1,0,5);
        put(0,0,0,5); put(1,1,0,6);
        chk("R7", "two edge incl. simultaneous", count, 32'd9);

        req_tag = "R9";
        wr(0, 32'h7);
        put(1,1,1,6);
        chk("R9", "zero marker clears", count, 32'd0);
        put(1,1,0,4);
        wr(0, 32'h3);
        wr(3, 32'd4);
        put(1,1,1,6);
        chk("R9", "button leaves count", count, 32'd4);
        put(0,0,0,5);

        req_tag = "R10";
        wr(3, 32'd3);
        wr(2, 32'd5);
        for (int k = 0; k < 3; k++) begin put(1,0,0,4); put(0,0,0,4); end
        chk("R10", "over max count", count, 32'd6);
        chk("R10", "over max flag", {31'b0, max_flag}, 32'd1);
        wr(4, 32'h7);
        wr(0, 32'h203);
        put(1,0,0,4); put(0,0,0,5);
        chk("R10", "max auto-zero", count, 32'd0);
        chk("R10", "max flag stays clear", {31'b0, max_flag}, 32'd0);

        req_tag = "R11";
        wr(1, 32'hFFFF_FFFE);
        for (int k = 0; k < 3; k++) begin put(0,1,0,4); put(0,0,0,4); end
        chk("R11", "under min count", count, 32'hFFFF_FFFD);
        chk("R11", "under min flag", {31'b0, min_flag}, 32'd1);
        wr(0, 32'h103);
        put(0,1,0,4); put(0,0,0,5);
        chk("R11", "min auto-zero", count, 32'd0);

        req_tag = "R12";
        wr(3, 32'h1234_5678);
        @(negedge clk);
        chk("R12", "load", count, 32'h1234_5678);
        repeat (3) @(negedge clk);
        summary();
    end

endmodule